// File: doc/BRIEF.md
# Processor Interrupt and Halt Controller

This block holds the interrupt-control state of a small 8-bit processor core. It keeps the two interrupt-enable bits: the live enable and the saved copy used across a non-maskable service. It catches edges on the non-maskable line and raises a request that waits until the sequencer accepts it. After an enable instruction it holds back maskable interrupts for exactly one more instruction. It also tracks the halted state and stores the 2-bit interrupt mode.

The instruction sequencer drives one-cycle strobes into the block. One strobe fires for each enable, disable or halt instruction that completes. Another fires at every instruction boundary. Two more fire when the sequencer accepts a non-maskable or a maskable interrupt. The sequencer reads the two request outputs at each boundary and starts the matching service sequence. The request outputs are combinational from registered state and the maskable level. Every other output is a register that updates on the clock edge where its strobe is sampled.

Top module: `irq_halt_ctrl`

## Requirements
- R1: A pending non-maskable request is set only by a low-to-high change of `nmi_in` sampled on two consecutive clock edges. Holding `nmi_in` high after the request has been accepted does not set it again. Dropping and raising the line again does set it.
- R2: `take_nmi` is 1 exactly while a non-maskable request is pending. `nmi_ack` clears the pending request, copies the live enable into the saved enable, and clears the live enable.
- R3: `ei_stb` makes `iff1_o` and `iff2_o` both 1 on the next cycle. The enable also arms a shadow, which keeps `take_irq` at 0 until a later `boundary_stb` cycle that does not carry `ei_stb`.
- R4: `di_stb` makes `iff1_o` and `iff2_o` both 0 on the next cycle.
- R5: `take_irq` is 1 exactly when `irq_lvl` is 1, the live enable is 1, no enable shadow is armed and no non-maskable request is pending. A pending non-maskable request always wins.
- R6: `irq_ack` makes `iff1_o` and `iff2_o` both 0 on the next cycle.
- R7: `halt_stb` makes `halt_o` 1 on the next cycle. A further `halt_stb` while halted leaves `halt_o` at 1 with no change.
- R8: `nmi_ack` or `irq_ack` makes `halt_o` 0 on the next cycle, even if `halt_stb` arrives in the same cycle.
- R9: While `rst_n` is 0, the live and saved enables, the pending non-maskable request, the enable shadow, `halt_o` and `im_o` are all 0.
- R10: `im_wr` loads `im_val` into `im_o` when `im_val` is 0, 1 or 2. The value 3 is ignored and `im_o` keeps its old value.
- R11: If several enable-changing strobes arrive in one cycle, the priority is `nmi_ack`, then `irq_ack`, then `di_stb`, then `ei_stb`. With none of them present, both enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 1 | Maskable interrupt level |
| nmi_in | input | 1 | Non-maskable interrupt line, edge-detected |
| ei_stb | input | 1 | Enable instruction completed |
| di_stb | input | 1 | Disable instruction completed |
| halt_stb | input | 1 | Halt instruction executed |
| boundary_stb | input | 1 | Instruction boundary |
| nmi_ack | input | 1 | Sequencer accepts the non-maskable request |
| irq_ack | input | 1 | Sequencer accepts the maskable request |
| im_wr | input | 1 | Interrupt-mode write strobe |
| im_val | input | 2 | Interrupt-mode value to write |
| take_nmi | output | 1 | Non-maskable request to the sequencer |
| take_irq | output | 1 | Maskable request to the sequencer |
| halt_o | output | 1 | Halted state |
| iff1_o | output | 1 | Live interrupt enable |
| iff2_o | output | 1 | Saved interrupt enable |
| im_o | output | 2 | Current interrupt mode |

## Verification
The assertions check the following on every cycle:
- the live enable is never 1 while the saved one is 0;
- a pending non-maskable request is always preceded by a sampled edge;
- the maskable request never coexists with a non-maskable one or with a clear enable;
- acceptance always ends the halt;
- the mode register never holds the reserved value.

Some behaviours only the bench's scenarios can show:
- the one-instruction shadow after enable, over a real sequence of boundaries;
- the missing re-trigger on a held line;
- the full priority table over every strobe combination from both enable states;
- the reset clearing state that was built up beforehand.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int IM_W = 2;

  typedef enum logic [IM_W-1:0] {
    IM_FIXED  = 2'd0,
    IM_RST38  = 2'd1,
    IM_VECTOR = 2'd2,
    IM_RSVD   = 2'd3
  } imode_t;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic ack,
  output logic pending
);
  logic line_q, line_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = nmi_in & ~line_q;

  always_comb begin
    line_d = nmi_in;
    pend_d = pend_q;
    if (rise)     pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      line_q <= line_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  // R1: a fresh pending request must follow a sampled rising edge
  a_r1_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !$past(pend_q)) |-> ($past(nmi_in) && !$past(line_q)));
endmodule

// File: rtl/iff_unit.sv
module iff_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic boundary_stb,
  input  logic nmi_ack,
  input  logic irq_ack,
  output logic iff1,
  output logic iff2,
  output logic shadow
);
  logic iff1_q, iff1_d;
  logic iff2_q, iff2_d;
  logic shd_q, shd_d;

  always_comb begin
    iff1_d = iff1_q;
    iff2_d = iff2_q;
    if (nmi_ack) begin
      iff2_d = iff1_q;
      iff1_d = 1'b0;
    end else if (irq_ack || di_stb) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (ei_stb) begin
      iff1_d = 1'b1;
      iff2_d = 1'b1;
    end
  end

  always_comb begin
    shd_d = shd_q;
    if (ei_stb)            shd_d = 1'b1;
    else if (boundary_stb) shd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      shd_q  <= 1'b0;
    end else begin
      iff1_q <= iff1_d;
      iff2_q <= iff2_d;
      shd_q  <= shd_d;
    end
  end

  assign iff1   = iff1_q;
  assign iff2   = iff2_q;
  assign shadow = shd_q;

  // R3: an uncontested enable sets both bits
  a_r3_ei_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_stb && !di_stb && !nmi_ack && !irq_ack) |=> (iff1_q && iff2_q));
  // R3: the live enable never stands without the saved one
  a_r3_live_needs_saved: assert property (@(posedge clk) disable iff (!rst_n)
    iff1_q |-> iff2_q);
  // R2: non-maskable acceptance saves the live enable and clears it
  a_r2_nmi_saves: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> (!iff1_q && (iff2_q == $past(iff1_q))));
  // R6: maskable acceptance clears both bits
  a_r6_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !nmi_ack) |=> (!iff1_q && !iff2_q));
endmodule

// File: rtl/halt_unit.sv
module halt_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_stb,
  input  logic wake,
  output logic halted
);
  logic halt_q, halt_d;

  always_comb begin
    halt_d = halt_q;
    if (wake)          halt_d = 1'b0;
    else if (halt_stb) halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  assign halted = halt_q;

  // R8: acceptance always releases the halt
  a_r8_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !halt_q);
  // R7: a halt without acceptance enters or stays halted
  a_r7_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_stb && !wake) |=> halt_q);
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_lvl,
  input  logic            nmi_in,
  input  logic            ei_stb,
  input  logic            di_stb,
  input  logic            halt_stb,
  input  logic            boundary_stb,
  input  logic            nmi_ack,
  input  logic            irq_ack,
  input  logic            im_wr,
  input  logic [IM_W-1:0] im_val,
  output logic            take_nmi,
  output logic            take_irq,
  output logic            halt_o,
  output logic            iff1_o,
  output logic            iff2_o,
  output logic [IM_W-1:0] im_o
);
  logic   nmi_pend;
  logic   iff1_w, iff2_w, shadow_w;
  imode_t im_q, im_d;

  nmi_edge_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_in  (nmi_in),
    .ack     (nmi_ack),
    .pending (nmi_pend)
  );

  iff_unit u_iff (
    .clk          (clk),
    .rst_n        (rst_n),
    .ei_stb       (ei_stb),
    .di_stb       (di_stb),
    .boundary_stb (boundary_stb),
    .nmi_ack      (nmi_ack),
    .irq_ack      (irq_ack),
    .iff1         (iff1_w),
    .iff2         (iff2_w),
    .shadow       (shadow_w)
  );

  halt_unit u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_stb (halt_stb),
    .wake     (nmi_ack | irq_ack),
    .halted   (halt_o)
  );

  always_comb begin
    im_d = im_q;
    if (im_wr && (imode_t'(im_val) != IM_RSVD)) im_d = imode_t'(im_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) im_q <= IM_FIXED;
    else        im_q <= im_d;
  end

  assign take_nmi = nmi_pend;
  assign take_irq = irq_lvl & iff1_w & ~shadow_w & ~nmi_pend;
  assign iff1_o   = iff1_w;
  assign iff2_o   = iff2_w;
  assign im_o     = im_q;

  // R5: a maskable request needs the live enable and yields to the non-maskable one
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (iff1_o && !take_nmi && irq_lvl));
  // R10: the reserved mode never gets stored
  a_r10_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    im_o != 2'd3);
endmodule

// File: tb/sim_irq_halt_ctrl.sv
`timescale 1ns/1ps
module sim_irq_halt_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic irq_lvl, nmi_in, ei_stb, di_stb, halt_stb, boundary_stb;
  logic nmi_ack, irq_ack, im_wr;
  logic [1:0] im_val;
  logic take_nmi, take_irq, halt_o, iff1_o, iff2_o;
  logic [1:0] im_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_halt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .nmi_in(nmi_in),
    .ei_stb(ei_stb), .di_stb(di_stb), .halt_stb(halt_stb),
    .boundary_stb(boundary_stb), .nmi_ack(nmi_ack), .irq_ack(irq_ack),
    .im_wr(im_wr), .im_val(im_val), .take_nmi(take_nmi), .take_irq(take_irq),
    .halt_o(halt_o), .iff1_o(iff1_o), .iff2_o(iff2_o), .im_o(im_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ei_stb = 0; di_stb = 0; halt_stb = 0; boundary_stb = 0;
    nmi_ack = 0; irq_ack = 0; im_wr = 0;
  endtask

  task automatic do_ei();
    ei_stb = 1; boundary_stb = 1; step(); idle();
    boundary_stb = 1; step(); idle();
  endtask

  task automatic do_di();
    di_stb = 1; boundary_stb = 1; step(); idle();
  endtask

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_lvl = 0; nmi_in = 0; im_val = 0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 iff1", iff1_o, 0); chk("R9 iff2", iff2_o, 0);
    chk("R9 halt", halt_o, 0); chk("R9 im", im_o, 0);
    chk("R9 take_nmi", take_nmi, 0); chk("R9 take_irq", take_irq, 0);
    rst_n = 1;
    step();

    // R10: mode writes, value 3 ignored
    begin
      int seq [5] = '{1, 3, 2, 0, 3};
      int model = 0;
      foreach (seq[i]) begin
        im_wr = 1; im_val = seq[i][1:0]; step(); idle();
        if (seq[i] != 3) model = seq[i];
        chk("R10 mode", im_o, model);
      end
    end

    // R3: enable with shadow
    irq_lvl = 1;
    ei_stb = 1; boundary_stb = 1; step(); idle();
    chk("R3 iff1 after ei", iff1_o, 1); chk("R3 iff2 after ei", iff2_o, 1);
    chk("R3 shadow blocks irq", take_irq, 0);
    boundary_stb = 1; step(); idle();
    chk("R5 irq after shadow", take_irq, 1);
    irq_lvl = 0; #1;
    chk("R5 no level", take_irq, 0);

    // R6: maskable acceptance
    irq_lvl = 1; #1;
    irq_ack = 1; step(); idle();
    chk("R6 iff1", iff1_o, 0); chk("R6 iff2", iff2_o, 0);
    chk("R5 disabled", take_irq, 0);
    irq_lvl = 0;

    // R4: disable
    do_ei();
    do_di();
    chk("R4 iff1", iff1_o, 0); chk("R4 iff2", iff2_o, 0);

    // R1/R2/R5: non-maskable edge, priority, acceptance
    do_ei();
    irq_lvl = 1;
    nmi_in = 1; step();
    chk("R1 edge latched", take_nmi, 1);
    chk("R5 nmi priority", take_irq, 0);
    nmi_ack = 1; step(); idle();
    chk("R2 pend cleared", take_nmi, 0);
    chk("R2 iff1 cleared", iff1_o, 0); chk("R2 iff2 saved", iff2_o, 1);
    step(); step(); step();
    chk("R1 held level no retrigger", take_nmi, 0);
    nmi_in = 0; step();
    nmi_in = 1; step();
    chk("R1 new edge", take_nmi, 1);
    nmi_ack = 1; step(); idle();
    chk("R2 second ack iff2", iff2_o, 0);
    nmi_in = 0; irq_lvl = 0; step();

    // R7/R8: halt
    halt_stb = 1; step(); idle();
    chk("R7 enter halt", halt_o, 1);
    halt_stb = 1; step(); idle();
    chk("R7 repeat halt", halt_o, 1);
    nmi_ack = 1; step(); idle();
    chk("R8 nmi ack wakes", halt_o, 0);
    halt_stb = 1; step(); idle();
    halt_stb = 1; irq_ack = 1; step(); idle();
    chk("R8 irq ack wakes over halt", halt_o, 0);

    // R11: priority sweep over all strobe combinations from both enable states
    for (int s = 0; s < 2; s++) begin
      for (int code = 0; code < 16; code++) begin
        int e1, e2;
        if (s == 1) do_ei(); else do_di();
        ei_stb = code[0]; di_stb = code[1]; irq_ack = code[2]; nmi_ack = code[3];
        step(); idle();
        if (code[3])      begin e1 = 0; e2 = s; end
        else if (code[2]) begin e1 = 0; e2 = 0; end
        else if (code[1]) begin e1 = 0; e2 = 0; end
        else if (code[0]) begin e1 = 1; e2 = 1; end
        else              begin e1 = s; e2 = s; end
        chk("R11 iff1", iff1_o, e1);
        chk("R11 iff2", iff2_o, e2);
      end
    end

    // R9: reset clears built-up state
    do_ei();
    im_wr = 1; im_val = 2; step(); idle();
    halt_stb = 1; step(); idle();
    nmi_in = 1; step();
    rst_n = 0; #1;
    chk("R9 async iff1", iff1_o, 0); chk("R9 async iff2", iff2_o, 0);
    chk("R9 async halt", halt_o, 0); chk("R9 async im", im_o, 0);
    chk("R9 async nmi", take_nmi, 0);
    nmi_in = 0; step(); rst_n = 1; step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule